// File: doc/BRIEF.md
# Peripheral Quadrant Write Guard

This block keeps one write-protection bit for each 256-byte quadrant of eight 1 KB peripheral frames and applies those bits to the accesses on a peripheral bus. Software changes the 32 protection bits through two write views. The set view turns bits on and the clear view turns bits off. Only privileged masters can change the bits, and both views read back the same value.

Each frame has a static 2-bit occupancy setting. It states whether the slave in that frame spans the whole frame, two aligned quadrant pairs, or individual quadrants. That setting decides which protection bits exist and which bit guards each quadrant. Bits that do not exist read as zero and cannot be set.

Every bus access is registered once. Reads, privileged writes and user writes to unguarded quadrants are forwarded to the peripheral side. A user write to a guarded quadrant is dropped, and a violation pulse is raised in its place.

Top module: `periph_quad_guard`

## Requirements
- R1: After reset, all protection bits read as 0 and `fwd_req_o` and `violation_o` are 0.
- R2: A privileged write to the set view (`reg_sel_i`=0) turns on every implemented bit whose write-data bit is 1. Bits written with 0 keep their value. The new value is visible on `reg_rdata_o` right after the clock edge.
- R3: A privileged write to the clear view (`reg_sel_i`=1) turns off every bit whose write-data bit is 1. Bits written with 0 keep their value. `reg_rdata_o` returns the same value whichever view is selected.
- R4: A user-mode write (`reg_priv_i`=0) to either view leaves every protection bit unchanged.
- R5: The occupancy of frame f is `frame_mode_i[2f+1:2f]`, where 0 means whole frame, 1 means quadrant pairs, and 2 or 3 mean single quadrants. Protection bit 4f+q belongs to quadrant q of frame f. In whole-frame mode only bit 4f exists, and it guards all four quadrants.
- R6: In pair mode only bits 4f and 4f+2 exist. Bit 4f guards quadrants 0 and 1, and bit 4f+2 guards quadrants 2 and 3.
- R7: In single mode all four bits of the frame exist, and each bit guards its own quadrant.
- R8: A write to a bit that does not exist has no effect, and that bit always reads as 0.
- R9: The guard takes the frame from `bus_addr_i[12:10]` and the quadrant from `bus_addr_i[9:8]`. A user write to a guarded quadrant is not forwarded, and `violation_o` is 1 for exactly that access, one cycle after it is presented.
- R10: Reads, privileged writes and user writes to unguarded quadrants appear on `fwd_req_o`, `fwd_we_o` and `fwd_addr_o` one cycle after they are presented, with the same address and direction.
- R11: `violation_o` is never 1 at the same time as `fwd_req_o`, and it is raised only for user-mode writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_mode_i | input | 16 | Static occupancy, 2 bits per frame |
| reg_req_i | input | 1 | Protection register access strobe |
| reg_we_i | input | 1 | Register access is a write |
| reg_sel_i | input | 1 | 0 selects the set view, 1 selects the clear view |
| reg_priv_i | input | 1 | Register access is privileged |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Protection bits (same for both views) |
| bus_req_i | input | 1 | Peripheral access request |
| bus_we_i | input | 1 | Peripheral access is a write |
| bus_priv_i | input | 1 | Peripheral access is privileged |
| bus_addr_i | input | 13 | Peripheral access address |
| fwd_req_o | output | 1 | Forwarded request |
| fwd_we_o | output | 1 | Forwarded write flag |
| fwd_addr_o | output | 13 | Forwarded address |
| violation_o | output | 1 | Blocked user write pulse |

## Verification
The bound checker watches every cycle for the following:
- Forwarding and violation never occur together.
- A violation always comes from a user-mode write.
- Reads and privileged accesses are always forwarded.
- User-mode register writes never change the readback.
- Bits that do not exist read as zero in every occupancy mode.

Only the bench scenarios can show that the right bit guards each quadrant, because that depends on the programmed values. The same applies to pair and whole-frame aliasing, to the set and clear views working as intended, and to a violation pulse ending after a single cycle.

// File: rtl/quad_guard_pkg.sv
package quad_guard_pkg;
  localparam int QUADS  = 4;
  localparam int QUAD_W = 2;

  typedef enum logic [1:0] {
    OCC_FULL   = 2'd0,
    OCC_PAIR   = 2'd1,
    OCC_SINGLE = 2'd2,
    OCC_RSVD   = 2'd3
  } occ_mode_e;

  // bits that exist inside one frame
  function automatic logic [QUADS-1:0] impl_mask(occ_mode_e m);
    case (m)
      OCC_FULL: return 4'b0001;
      OCC_PAIR: return 4'b0101;
      default:  return 4'b1111;
    endcase
  endfunction

  // quadrant whose bit guards quadrant q
  function automatic logic [QUAD_W-1:0] owner_quad(occ_mode_e m, logic [QUAD_W-1:0] q);
    case (m)
      OCC_FULL: return 2'd0;
      OCC_PAIR: return {q[1], 1'b0};
      default:  return q;
    endcase
  endfunction
endpackage

// File: rtl/quad_guard_mask.sv
module quad_guard_mask
  import quad_guard_pkg::*;
#(
  parameter int N_FRAMES = 8,
  localparam int BITS    = N_FRAMES * QUADS
) (
  input  logic [2*N_FRAMES-1:0] frame_mode_i,
  output logic [BITS-1:0]       impl_o
);
  for (genvar f = 0; f < N_FRAMES; f++) begin : g_frame
    assign impl_o[f*QUADS +: QUADS] = impl_mask(occ_mode_e'(frame_mode_i[2*f +: 2]));
  end
endmodule

// File: rtl/quad_guard_regs.sv
module quad_guard_regs
  import quad_guard_pkg::*;
#(
  parameter int N_FRAMES = 8,
  localparam int BITS    = N_FRAMES * QUADS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic            sel_i,
  input  logic            priv_i,
  input  logic [BITS-1:0] wdata_i,
  input  logic [BITS-1:0] impl_i,
  output logic [BITS-1:0] prot_o
);
  logic [BITS-1:0] prot_q, prot_d;
  logic            wr_ok;

  assign wr_ok = req_i & we_i & priv_i;

  always_comb begin
    prot_d = prot_q;
    if (wr_ok) begin
      if (!sel_i) prot_d = prot_q | wdata_i;
      else        prot_d = prot_q & ~wdata_i;
    end
    prot_d = prot_d & impl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prot_q <= '0;
    else         prot_q <= prot_d;
  end

  // masking on read covers a change of occupancy after programming
  assign prot_o = prot_q & impl_i;
endmodule

// File: rtl/quad_guard_check.sv
module quad_guard_check
  import quad_guard_pkg::*;
#(
  parameter int N_FRAMES  = 8,
  parameter int ADDR_W    = 13,
  parameter int QUAD_LSB  = 8,
  localparam int FRAME_LSB = QUAD_LSB + QUAD_W,
  localparam int FRAME_W   = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1,
  localparam int BITS      = N_FRAMES * QUADS,
  localparam int IDX_W     = FRAME_W + QUAD_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*N_FRAMES-1:0] frame_mode_i,
  input  logic [BITS-1:0]       prot_i,
  input  logic                  bus_req_i,
  input  logic                  bus_we_i,
  input  logic                  bus_priv_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  output logic                  fwd_req_o,
  output logic                  fwd_we_o,
  output logic [ADDR_W-1:0]     fwd_addr_o,
  output logic                  violation_o
);
  logic [FRAME_W-1:0] frame;
  logic [QUAD_W-1:0]  quad, owner;
  logic [IDX_W-1:0]   idx;
  occ_mode_e          mode;
  logic               guarded, block;

  assign frame = bus_addr_i[FRAME_LSB +: FRAME_W];
  assign quad  = bus_addr_i[QUAD_LSB +: QUAD_W];

  always_comb begin
    mode    = OCC_SINGLE;
    guarded = 1'b0;
    if (int'(frame) < N_FRAMES) begin
      mode    = occ_mode_e'(frame_mode_i[2*int'(frame) +: 2]);
      owner   = owner_quad(mode, quad);
      idx     = {frame, owner};
      guarded = prot_i[idx];
    end else begin
      owner   = quad;
      idx     = '0;
    end
  end

  assign block = bus_req_i & bus_we_i & ~bus_priv_i & guarded;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_req_o   <= 1'b0;
      fwd_we_o    <= 1'b0;
      fwd_addr_o  <= '0;
      violation_o <= 1'b0;
    end else begin
      fwd_req_o   <= bus_req_i & ~block;
      fwd_we_o    <= bus_we_i;
      fwd_addr_o  <= bus_addr_i;
      violation_o <= block;
    end
  end
endmodule

// File: rtl/periph_quad_guard.sv
module periph_quad_guard
  import quad_guard_pkg::*;
#(
  parameter int N_FRAMES = 8,
  parameter int ADDR_W   = 13,
  localparam int BITS    = N_FRAMES * QUADS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*N_FRAMES-1:0] frame_mode_i,
  input  logic                  reg_req_i,
  input  logic                  reg_we_i,
  input  logic                  reg_sel_i,
  input  logic                  reg_priv_i,
  input  logic [BITS-1:0]       reg_wdata_i,
  output logic [BITS-1:0]       reg_rdata_o,
  input  logic                  bus_req_i,
  input  logic                  bus_we_i,
  input  logic                  bus_priv_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  output logic                  fwd_req_o,
  output logic                  fwd_we_o,
  output logic [ADDR_W-1:0]     fwd_addr_o,
  output logic                  violation_o
);
  logic [BITS-1:0] impl, prot;

  quad_guard_mask #(.N_FRAMES(N_FRAMES)) u_mask (
    .frame_mode_i (frame_mode_i),
    .impl_o       (impl)
  );

  quad_guard_regs #(.N_FRAMES(N_FRAMES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (reg_req_i),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .priv_i  (reg_priv_i),
    .wdata_i (reg_wdata_i),
    .impl_i  (impl),
    .prot_o  (prot)
  );

  assign reg_rdata_o = prot;

  quad_guard_check #(.N_FRAMES(N_FRAMES), .ADDR_W(ADDR_W)) u_check (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_mode_i (frame_mode_i),
    .prot_i       (prot),
    .bus_req_i    (bus_req_i),
    .bus_we_i     (bus_we_i),
    .bus_priv_i   (bus_priv_i),
    .bus_addr_i   (bus_addr_i),
    .fwd_req_o    (fwd_req_o),
    .fwd_we_o     (fwd_we_o),
    .fwd_addr_o   (fwd_addr_o),
    .violation_o  (violation_o)
  );
endmodule

// File: rtl/quad_guard_sva.sv
module quad_guard_sva #(
  parameter int N_FRAMES = 8,
  parameter int ADDR_W   = 13,
  localparam int BITS    = N_FRAMES * 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [2*N_FRAMES-1:0] frame_mode_i,
  input logic                  reg_req_i,
  input logic                  reg_we_i,
  input logic                  reg_priv_i,
  input logic [BITS-1:0]       reg_rdata_o,
  input logic                  bus_req_i,
  input logic                  bus_we_i,
  input logic                  bus_priv_i,
  input logic                  fwd_req_o,
  input logic                  violation_o
);
  assert_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fwd_req_o && violation_o));

  assert_viol_user_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(violation_o) |-> $past(bus_req_i && bus_we_i && !bus_priv_i));

  assert_read_fwd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && bus_req_i && !bus_we_i) |=> fwd_req_o);

  assert_priv_fwd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && bus_req_i && bus_priv_i) |=> fwd_req_o);

  assert_user_reg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && reg_we_i && !reg_priv_i) ##1 $stable(frame_mode_i)
      |-> $stable(reg_rdata_o));

  for (genvar f = 0; f < N_FRAMES; f++) begin : g_unimpl
    assert_full_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_mode_i[2*f +: 2] == 2'd0) |-> (reg_rdata_o[4*f+1 +: 3] == 3'b000));
    assert_pair_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_mode_i[2*f +: 2] == 2'd1) |-> (!reg_rdata_o[4*f+1] && !reg_rdata_o[4*f+3]));
  end
endmodule

bind periph_quad_guard quad_guard_sva #(.N_FRAMES(N_FRAMES), .ADDR_W(ADDR_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_mode_i (frame_mode_i),
  .reg_req_i    (reg_req_i),
  .reg_we_i     (reg_we_i),
  .reg_priv_i   (reg_priv_i),
  .reg_rdata_o  (reg_rdata_o),
  .bus_req_i    (bus_req_i),
  .bus_we_i     (bus_we_i),
  .bus_priv_i   (bus_priv_i),
  .fwd_req_o    (fwd_req_o),
  .violation_o  (violation_o)
);

// File: tb/periph_quad_guard_bench.sv
module periph_quad_guard_bench;
  localparam int N_FRAMES = 8;
  localparam int ADDR_W   = 13;
  // frame0 whole, frame1 pairs, frames2..7 single
  localparam logic [15:0] MODES = 16'hAAA4;

  // {we, priv, addr[12:0], exp_fwd, exp_viol}
  localparam int NV = 9;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 1'b0, 13'h0300, 1'b0, 1'b1},  // R5 f0 q3 guarded by bit0
    {1'b0, 1'b0, 13'h0300, 1'b1, 1'b0},  // R10 user read
    {1'b1, 1'b1, 13'h0200, 1'b1, 1'b0},  // R10 priv write
    {1'b1, 1'b0, 13'h0500, 1'b0, 1'b1},  // R6 f1 q1 via bit4
    {1'b1, 1'b0, 13'h0700, 1'b0, 1'b1},  // R6 f1 q3 via bit6
    {1'b1, 1'b0, 13'h0900, 1'b1, 1'b0},  // R7 f2 q1 cleared
    {1'b1, 1'b0, 13'h0A00, 1'b0, 1'b1},  // R7 f2 q2 set
    {1'b1, 1'b0, 13'h1800, 1'b1, 1'b0},  // R9 f6 unguarded
    {1'b1, 1'b0, 13'h1F00, 1'b0, 1'b1}   // R9 f7 q3
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [15:0]       frame_mode_i = MODES;
  logic              reg_req_i = 0, reg_we_i = 0, reg_sel_i = 0, reg_priv_i = 0;
  logic [31:0]       reg_wdata_i = '0;
  logic [31:0]       reg_rdata_o;
  logic              bus_req_i = 0, bus_we_i = 0, bus_priv_i = 0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic              fwd_req_o, fwd_we_o, violation_o;
  logic [ADDR_W-1:0] fwd_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  periph_quad_guard #(.N_FRAMES(N_FRAMES), .ADDR_W(ADDR_W)) u_periph_quad_guard (
    .clk_i, .rst_ni, .frame_mode_i, .reg_req_i, .reg_we_i, .reg_sel_i, .reg_priv_i,
    .reg_wdata_i, .reg_rdata_o, .bus_req_i, .bus_we_i, .bus_priv_i, .bus_addr_i,
    .fwd_req_o, .fwd_we_o, .fwd_addr_o, .violation_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic sel, logic priv, logic [31:0] d);
    reg_req_i = 1; reg_we_i = 1; reg_sel_i = sel; reg_priv_i = priv; reg_wdata_i = d;
    @(negedge clk_i);
    reg_req_i = 0; reg_we_i = 0;
  endtask

  task automatic bus_acc(logic we, logic priv, logic [ADDR_W-1:0] a);
    bus_req_i = 1; bus_we_i = we; bus_priv_i = priv; bus_addr_i = a;
    @(negedge clk_i);
  endtask

  task automatic bus_idle();
    bus_req_i = 0; bus_we_i = 0; bus_priv_i = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 rdata", reg_rdata_o, 32'h0);
    check("R1 fwd/viol", {30'b0, fwd_req_o, violation_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 set all: only implemented bits take
    reg_wr(1'b0, 1'b1, 32'hFFFF_FFFF);
    check("R2 set all", reg_rdata_o, 32'hFFFF_FF51);
    // R3 clear frame6 and f2 q1
    reg_wr(1'b1, 1'b1, 32'h0F00_0200);
    check("R3 clear", reg_rdata_o, 32'hF0FF_FD51);
    reg_sel_i = 1'b0;
    check("R3 view set", reg_rdata_o, 32'hF0FF_FD51);
    reg_sel_i = 1'b1;
    check("R3 view clr", reg_rdata_o, 32'hF0FF_FD51);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      bus_acc(v[16], v[15], v[14:2]);
      check($sformatf("R9/R10 vec%0d fwd", i), {31'b0, fwd_req_o}, {31'b0, v[1]});
      check($sformatf("R9/R11 vec%0d viol", i), {31'b0, violation_o}, {31'b0, v[0]});
      if (v[1]) check($sformatf("R10 vec%0d addr/we", i),
                      {18'b0, fwd_we_o, fwd_addr_o}, {18'b0, v[16], v[14:2]});
      bus_idle();
      @(negedge clk_i);
    end

    // R9 violation lasts one cycle
    bus_acc(1'b1, 1'b0, 13'h0000);
    check("R9 viol on", {31'b0, violation_o}, 32'h1);
    bus_idle();
    @(negedge clk_i);
    check("R9 viol off", {31'b0, violation_o}, 32'h0);

    // R6 clear lower pair bit of frame1
    reg_wr(1'b1, 1'b1, 32'h0000_0010);
    check("R6 clear bit4", reg_rdata_o, 32'hF0FF_FD41);
    bus_acc(1'b1, 1'b0, 13'h0500);
    check("R6 f1 q1 open", {30'b0, fwd_req_o, violation_o}, 32'h2);
    bus_acc(1'b1, 1'b0, 13'h0600);
    check("R6 f1 q2 guarded", {30'b0, fwd_req_o, violation_o}, 32'h1);
    bus_idle();

    // R8 writes to missing bits
    reg_wr(1'b0, 1'b1, 32'h0000_00AE);
    check("R8 missing bits", reg_rdata_o, 32'hF0FF_FD41);

    // R4 user writes ignored
    reg_wr(1'b0, 1'b0, 32'h0F00_0000);
    check("R4 user set", reg_rdata_o, 32'hF0FF_FD41);
    reg_wr(1'b1, 1'b0, 32'hFFFF_FFFF);
    check("R4 user clear", reg_rdata_o, 32'hF0FF_FD41);

    // R2 writing 0 keeps bits; R7 single-mode set
    reg_wr(1'b0, 1'b1, 32'h0100_0000);
    check("R2 set one", reg_rdata_o, 32'hF1FF_FD41);
    bus_acc(1'b1, 1'b0, 13'h1800);
    check("R7 f6 q0 guarded", {30'b0, fwd_req_o, violation_o}, 32'h1);
    bus_acc(1'b1, 1'b0, 13'h1900);
    check("R7 f6 q1 open", {30'b0, fwd_req_o, violation_o}, 32'h2);
    bus_idle();

    // R5 change frame0 to single mode: bits stored stay, f0 q1 now unguarded
    frame_mode_i = 16'hAAA6;
    #1;
    check("R5 remap rdata", reg_rdata_o, 32'hF1FF_FD41);
    bus_acc(1'b1, 1'b0, 13'h0100);
    check("R5 f0 q1 single", {30'b0, fwd_req_o, violation_o}, 32'h2);
    bus_idle();

    // R1 reset clears
    rst_ni = 1'b0;
    #1;
    check("R1 reset again", reg_rdata_o, 32'h0);
    check("R1 outputs reset", {30'b0, fwd_req_o, violation_o}, 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule